// File: doc/BRIEF.md
# Flash Bus Write Capture and Bus-State Decoder

This block sits behind the pins of an asynchronous byte-wide parallel flash interface and turns its three active-low strobes into clean events in a fast system-clock domain. Chip-enable, write-enable and output-enable are first passed through multi-flop synchronisers and then through a per-pin stability filter. After that they are combined. A write cycle is the interval in which both chip-enable and write-enable are low. Either strobe can open the cycle and either can close it. The block takes the address at the moment the cycle opens, which is the later of the two falling edges. It takes the data at the moment the cycle closes, which is the earlier of the two rising edges. It then emits a single-cycle write event that carries both values.

The block also classifies the bus in every cycle. The classes are deselected (standby), selected with outputs disabled, or a read that should drive the data pins. A separate inactivity timer raises an automatic-standby flag once no pin has moved for a configurable number of sample cycles. Address and data samples are delayed by the filter latency, so the captured values line up with the raw strobe edges. Filter length and idle timeout are parameters counted in system-clock cycles.

Top module: `fbus_write_capture`

## Requirements
- R1: A write event is a `wr_pulse` exactly one clock cycle wide. `wr_addr` holds the address that was present when the later of chip-enable and write-enable fell. `wr_addr` changes only together with `wr_pulse`.
- R2: `wr_data` holds the data present when the earlier of chip-enable and write-enable rose. It changes only together with `wr_pulse`.
- R3: If output-enable is low at any time while chip-enable and write-enable are both low, that write produces no event.
- R4: While chip-enable is high, strobes on the other pins produce no event. In this state `standby` is 1, `dq_drive` is 0 and `out_disable` is 0.
- R5: `dq_drive` is 1 exactly when the filtered pins show chip-enable low, output-enable low and write-enable high.
- R6: With chip-enable low and output-enable high, `out_disable` is 1 and `dq_drive` is 0.
- R7: A low pulse on chip-enable or write-enable lasting fewer than `GLITCH_CYC` sample cycles is ignored. One lasting `GLITCH_CYC`+1 cycles or longer takes effect.
- R8: `auto_standby` rises once no pin (strobes, address or data) has changed for `IDLE_CYC` sampled cycles. It stays 0 before that. Any pin change clears it.
- R9: `dq_drive` is unaffected by `auto_standby`: a read in progress keeps driving while the idle flag is set.
- R10: After reset, `wr_pulse`, `dq_drive`, `out_disable` and `auto_standby` are 0 and `standby` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_ce_n | input | 1 | Asynchronous chip-enable pin, active low |
| bus_we_n | input | 1 | Asynchronous write-enable pin, active low |
| bus_oe_n | input | 1 | Asynchronous output-enable pin, active low |
| bus_addr | input | AW (19) | Asynchronous address pins |
| bus_dq_in | input | DW (8) | Asynchronous data pins, input side |
| wr_pulse | output | 1 | One-cycle write event |
| wr_addr | output | AW (19) | Address captured for the last write event |
| wr_data | output | DW (8) | Data captured for the last write event |
| dq_drive | output | 1 | Data pins should be driven (read) |
| out_disable | output | 1 | Selected, outputs disabled |
| standby | output | 1 | Chip deselected |
| auto_standby | output | 1 | Bus inactive for the idle timeout |

## Verification
The hardest cases are those in which the two strobes swap roles and the address and data pins carry wrong values on the wrong side of each edge. In one such case chip-enable falls first while the address is still junk, and the valid address arrives only before write-enable falls. The data is valid only before the first rising strobe and becomes junk before the second. The stimulus table runs this pattern in both strobe orders. Each vector sets the junk values to the bitwise inverse of the valid ones, so a capture at the wrong edge shows up in every bit. Directed tests then cover pulses just below and just above the filter length, and a read held long enough for the idle flag to rise.

// File: rtl/fbw_pkg.sv
// Shared types for the flash bus write capture block.
// Assumes: nothing beyond IEEE 1800-2017.
package fbw_pkg;
    // Classification of the filtered bus strobes in one sample cycle.
    typedef enum logic [1:0] {
        BUS_DESELECT = 2'd0,
        BUS_HIZ      = 2'd1,
        BUS_READ     = 2'd2,
        BUS_WRITE    = 2'd3
    } bus_state_e;

    // Index of each strobe within the control vector.
    localparam int CTL_CE = 2;
    localparam int CTL_WE = 1;
    localparam int CTL_OE = 0;
    localparam int CTL_W  = 3;
endpackage

// File: rtl/fbw_sync.sv
// Multi-stage synchroniser for a vector of asynchronous pins.
// Assumes: multi-bit fields are quasi-static around the strobe edges that
// qualify them, so per-bit skew between stages is harmless.
module fbw_sync #(
    parameter int          W       = 8,
    parameter int          STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= din;
    end

    for (genvar g = 1; g < STAGES; g++) begin : g_stage
        // Further stages settle metastability.
        always_ff @(posedge clk) begin
            if (!rst_n) stg[g] <= RST_VAL;
            else        stg[g] <= stg[g-1];
        end
    end

    assign dout = stg[STAGES-1];
endmodule

// File: rtl/fbw_deglitch.sv
// Stability filter for one synchronised strobe: the output follows the input
// only after the input has differed from it for GLITCH_CYC consecutive
// samples. A clean edge therefore appears GLITCH_CYC cycles late.
// Assumes: GLITCH_CYC >= 2.
module fbw_deglitch #(
    parameter int   GLITCH_CYC = 3,
    parameter logic RST_VAL    = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(GLITCH_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(GLITCH_CYC - 1);

    logic [CW-1:0] cnt;

    // Count consecutive disagreeing samples, flip the output on the last one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            dout <= RST_VAL;
        end else if (din == dout) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            dout <= din;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/fbw_idle.sv
// Inactivity timer: flags when the sampled pin vector has not changed for
// IDLE_CYC consecutive cycles; any change restarts the count.
// Assumes: the input is already synchronised.
module fbw_idle #(
    parameter int          W        = 30,
    parameter int          IDLE_CYC = 15,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pins,
    output logic         idle
);
    localparam int CW = $clog2(IDLE_CYC + 1);
    localparam logic [CW-1:0] LIMIT = CW'(IDLE_CYC);

    logic [W-1:0]  prev;
    logic [CW-1:0] cnt;

    // Remember last sample and run a saturating quiet-cycle counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= RST_VAL;
            cnt  <= '0;
        end else begin
            prev <= pins;
            if (pins != prev)     cnt <= '0;
            else if (cnt != LIMIT) cnt <= cnt + 1'b1;
        end
    end

    assign idle = (cnt == LIMIT);
endmodule

// File: rtl/fbw_write_fsm.sv
// Write-cycle tracker. A cycle is open while filtered chip-enable and
// write-enable are both low. Address is captured as the cycle opens, data as
// it closes; a cycle that saw output-enable low is discarded. Address and
// data are delayed by DELAY cycles to match the strobe filter latency.
// Assumes: strobe inputs come from fbw_deglitch with GLITCH_CYC == DELAY.
module fbw_write_fsm #(
    parameter int AW    = 19,
    parameter int DW    = 8,
    parameter int DELAY = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ce_n_f,
    input  logic          we_n_f,
    input  logic          oe_n_f,
    input  logic [AW-1:0] addr_s,
    input  logic [DW-1:0] data_s,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data
);
    localparam int PW = AW + DW;

    logic [PW-1:0] pipe [DELAY];
    logic [AW-1:0] addr_d;
    logic [DW-1:0] data_d;
    logic          open_now;
    logic          open_q;
    logic          oe_seen;
    logic [AW-1:0] addr_q;

    // Head of the alignment delay line.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe[0] <= '0;
        else        pipe[0] <= {addr_s, data_s};
    end

    for (genvar g = 1; g < DELAY; g++) begin : g_dly
        // Remaining alignment stages.
        always_ff @(posedge clk) begin
            if (!rst_n) pipe[g] <= '0;
            else        pipe[g] <= pipe[g-1];
        end
    end

    assign {addr_d, data_d} = pipe[DELAY-1];
    assign open_now = !ce_n_f && !we_n_f;

    // Track the write window, capture at its edges, emit the event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            open_q   <= 1'b0;
            oe_seen  <= 1'b0;
            addr_q   <= '0;
            wr_pulse <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
        end else begin
            wr_pulse <= 1'b0;
            open_q   <= open_now;
            if (open_now && !open_q) begin
                addr_q  <= addr_d;
                oe_seen <= !oe_n_f;
            end else if (open_now && !oe_n_f) begin
                oe_seen <= 1'b1;
            end
            if (!open_now && open_q && !oe_seen && oe_n_f) begin
                wr_pulse <= 1'b1;
                wr_addr  <= addr_q;
                wr_data  <= data_d;
            end
        end
    end
endmodule

// File: rtl/fbus_write_capture.sv
// Top: synchronises and filters the asynchronous flash bus pins, extracts
// write events, classifies the bus state and reports bus inactivity.
// Assumes: clk is much faster than the bus cycle; GLITCH_CYC >= 2.
module fbus_write_capture #(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int SYNC_STG   = 2,
    parameter int GLITCH_CYC = 3,
    parameter int IDLE_CYC   = 15
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_ce_n,
    input  logic          bus_we_n,
    input  logic          bus_oe_n,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_dq_in,
    output logic          wr_pulse,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic          dq_drive,
    output logic          out_disable,
    output logic          standby,
    output logic          auto_standby
);
    import fbw_pkg::*;

    localparam int VW = CTL_W + AW + DW;
    localparam logic [VW-1:0] VEC_RST = {{CTL_W{1'b1}}, {(AW + DW){1'b0}}};
    localparam logic [CTL_W-1:0] CTL_RST = '1;

    logic [VW-1:0]    vec_s;
    logic [CTL_W-1:0] ctl_s;
    logic [CTL_W-1:0] ctl_f;
    logic [AW-1:0]    addr_s;
    logic [DW-1:0]    data_s;
    bus_state_e       bstate;

    fbw_sync #(.W(VW), .STAGES(SYNC_STG), .RST_VAL(VEC_RST)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_ce_n, bus_we_n, bus_oe_n, bus_addr, bus_dq_in}),
        .dout (vec_s)
    );

    assign {ctl_s, addr_s, data_s} = vec_s;

    for (genvar g = 0; g < CTL_W; g++) begin : g_flt
        fbw_deglitch #(.GLITCH_CYC(GLITCH_CYC), .RST_VAL(CTL_RST[g])) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (ctl_s[g]),
            .dout (ctl_f[g])
        );
    end

    fbw_write_fsm #(.AW(AW), .DW(DW), .DELAY(GLITCH_CYC)) u_wr (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_n_f  (ctl_f[CTL_CE]),
        .we_n_f  (ctl_f[CTL_WE]),
        .oe_n_f  (ctl_f[CTL_OE]),
        .addr_s  (addr_s),
        .data_s  (data_s),
        .wr_pulse(wr_pulse),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    fbw_idle #(.W(VW), .IDLE_CYC(IDLE_CYC), .RST_VAL(VEC_RST)) u_idle (
        .clk  (clk),
        .rst_n(rst_n),
        .pins (vec_s),
        .idle (auto_standby)
    );

    // Classify the filtered strobes; chip-enable high overrides everything.
    always_comb begin
        if (ctl_f[CTL_CE])       bstate = BUS_DESELECT;
        else if (ctl_f[CTL_OE])  bstate = BUS_HIZ;
        else if (ctl_f[CTL_WE])  bstate = BUS_READ;
        else                     bstate = BUS_WRITE;
    end

    assign standby     = (bstate == BUS_DESELECT);
    assign out_disable = (bstate == BUS_HIZ);
    assign dq_drive    = (bstate == BUS_READ);
endmodule

// File: rtl/fbw_checker.sv
// Port-level properties of fbus_write_capture, attached by bind.
module fbw_checker #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_pulse,
    input logic [AW-1:0] wr_addr,
    input logic [DW-1:0] wr_data,
    input logic          dq_drive,
    input logic          out_disable,
    input logic          standby
);
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_pulse |=> !wr_pulse);
    a_r1_addr_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_addr) |-> wr_pulse);
    a_r2_data_with_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(wr_data) |-> wr_pulse);
    a_r4_standby_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        standby |-> (!dq_drive && !out_disable));
    a_r5_state_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({dq_drive, out_disable, standby}));
    a_r6_disable_no_drive: assert property (@(posedge clk) disable iff (!rst_n)
        out_disable |-> !dq_drive);
endmodule

bind fbus_write_capture fbw_checker #(.AW(AW), .DW(DW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_pulse   (wr_pulse),
    .wr_addr    (wr_addr),
    .wr_data    (wr_data),
    .dq_drive   (dq_drive),
    .out_disable(out_disable),
    .standby    (standby)
);

// File: tb/sim_fbus_write_capture.sv
module sim_fbus_write_capture;
    localparam int AW = 19;
    localparam int DW = 8;
    localparam int GLITCH_CYC = 3;
    localparam int IDLE_CYC = 15;
    // Vector: {strobe order, oe low during write, address, data}
    localparam int VW = 2 + AW + DW;
    localparam int NV = 6;
    localparam logic [VW-1:0] VECS [NV] = '{
        {1'b0, 1'b0, 19'h05555, 8'hAA},
        {1'b1, 1'b0, 19'h02AAA, 8'h55},
        {1'b0, 1'b1, 19'h7FFFF, 8'h00},
        {1'b1, 1'b0, 19'h00000, 8'hFF},
        {1'b1, 1'b1, 19'h12345, 8'h3C},
        {1'b0, 1'b0, 19'h40001, 8'h81}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] dq = '0;
    logic wr_pulse, dq_drive, out_disable, standby, auto_standby;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int checks = 0, errors = 0, pulses = 0;
    logic [AW-1:0] got_a = '0;
    logic [DW-1:0] got_d = '0;
    bit done = 0;

    always #5 clk = ~clk;

    fbus_write_capture #(.AW(AW), .DW(DW), .GLITCH_CYC(GLITCH_CYC),
                         .IDLE_CYC(IDLE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_ce_n(ce_n), .bus_we_n(we_n),
        .bus_oe_n(oe_n), .bus_addr(addr), .bus_dq_in(dq),
        .wr_pulse(wr_pulse), .wr_addr(wr_addr), .wr_data(wr_data),
        .dq_drive(dq_drive), .out_disable(out_disable), .standby(standby),
        .auto_standby(auto_standby)
    );

    // Record every write event, sampled mid-cycle.
    always @(negedge clk) begin
        if (rst_n && wr_pulse) begin
            pulses++;
            got_a = wr_addr;
            got_d = wr_data;
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_write(input logic order, input logic oe_low,
                            input logic [AW-1:0] a, input logic [DW-1:0] d);
        oe_n = 1'b1; addr = ~a; dq = ~d; idle_n(8);
        if (order) we_n = 1'b0; else ce_n = 1'b0;
        idle_n(8);
        addr = a; idle_n(8);
        if (order) ce_n = 1'b0; else we_n = 1'b0;
        idle_n(8);
        if (oe_low) begin oe_n = 1'b0; idle_n(5); oe_n = 1'b1; idle_n(5); end
        addr = ~a; dq = d; idle_n(8);
        if (order) ce_n = 1'b1; else we_n = 1'b1;
        idle_n(8);
        dq = ~d; idle_n(8);
        if (order) we_n = 1'b1; else ce_n = 1'b1;
        idle_n(10);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int base;
        idle_n(5);
        // R10: reset state
        chk(!wr_pulse && !dq_drive && !out_disable && !auto_standby && standby,
            "R10 reset", {wr_pulse, dq_drive, out_disable, auto_standby, standby}, 5'b00001);
        rst_n = 1'b1; idle_n(5);
        chk(standby && !dq_drive, "R10 after reset", standby, 1);

        // Table walk: R1, R2, R3
        for (int i = 0; i < NV; i++) begin
            logic order, oel;
            logic [AW-1:0] a;
            logic [DW-1:0] d;
            {order, oel, a, d} = VECS[i];
            base = pulses;
            do_write(order, oel, a, d);
            if (oel) begin
                chk(pulses == base, "R3 oe low cancels", pulses - base, 0);
            end else begin
                chk(pulses == base + 1, "R1 one event", pulses - base, 1);
                chk(got_a == a, "R1 address at later fall", got_a, a);
                chk(got_d == d, "R2 data at earlier rise", got_d, d);
            end
        end

        // R4: write strobes with chip deselected
        base = pulses;
        oe_n = 1'b1; ce_n = 1'b1; idle_n(6);
        repeat (3) begin we_n = 1'b0; idle_n(8); we_n = 1'b1; idle_n(8); end
        chk(pulses == base, "R4 no event when deselected", pulses - base, 0);
        chk(standby && !dq_drive && !out_disable, "R4 standby outputs",
            {standby, dq_drive, out_disable}, 3'b100);

        // R7: short write-enable glitch rejected, longer one accepted
        ce_n = 1'b0; idle_n(10);
        base = pulses;
        we_n = 1'b0; idle_n(GLITCH_CYC - 1); we_n = 1'b1; idle_n(12);
        chk(pulses == base, "R7 short we glitch ignored", pulses - base, 0);
        we_n = 1'b0; idle_n(GLITCH_CYC + 1); we_n = 1'b1; idle_n(12);
        chk(pulses == base + 1, "R7 long we pulse accepted", pulses - base, 1);
        // R7: short chip-enable glitch while write-enable is low
        ce_n = 1'b1; idle_n(10); we_n = 1'b0; idle_n(10);
        base = pulses;
        ce_n = 1'b0; idle_n(GLITCH_CYC - 1); ce_n = 1'b1; idle_n(12);
        chk(pulses == base, "R7 short ce glitch ignored", pulses - base, 0);
        we_n = 1'b1; idle_n(10);

        // R6: selected, outputs disabled
        ce_n = 1'b0; oe_n = 1'b1; idle_n(10);
        chk(out_disable && !dq_drive && !standby, "R6 output disable",
            {out_disable, dq_drive, standby}, 3'b100);
        // R5: read
        oe_n = 1'b0; idle_n(8);
        chk(dq_drive && !out_disable && !standby, "R5 read drives",
            {dq_drive, out_disable, standby}, 3'b100);
        // R8: not yet idle
        chk(!auto_standby, "R8 idle flag early", auto_standby, 0);
        idle_n(IDLE_CYC + 10);
        chk(auto_standby, "R8 idle flag raised", auto_standby, 1);
        // R9: read continues while idle
        chk(dq_drive, "R9 drive during auto standby", dq_drive, 1);
        addr = addr + 1'b1; idle_n(4);
        chk(!auto_standby, "R8 activity clears idle", auto_standby, 0);
        // R5: write-enable low removes read
        we_n = 1'b0; idle_n(8);
        chk(!dq_drive, "R5 we low stops drive", dq_drive, 0);
        oe_n = 1'b1; we_n = 1'b1; ce_n = 1'b1; idle_n(10);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule